// File: doc/BRIEF.md
# Pipelined Multi-Master Bus Interconnect Core

This block is the central fabric of a pipelined on-chip bus that connects several initiators to several targets. A fixed-priority arbiter chooses one initiator at a time. That initiator's address and control are broadcast to every target. A central decoder turns the upper address bits into a one-hot target select. Address, write data and read data each use their own dedicated, multiplexed path. There is no shared tristate bus.

On this bus the address phase of one transfer overlaps the data phase of the transfer before it. For that reason the block captures the decoded target, and the initiator that owned the address phase, only at an accepted transfer boundary, which is a cycle with the ready signal high. The read data, ready and response returned to the initiators then come from that captured target. The write data sent to the targets comes from that captured initiator.

When a target holds ready low, the data phase is stretched. The address phase in flight is stretched with it, and the grant is frozen. An address that hits no target region goes to an internal default target, which answers with an error response.

Top module: `pbus_fabric`

## Requirements
- R1: `m_grant` is always one-hot. After reset it selects initiator 0.
- R2: At each rising edge where `r_ready` is 1, the grant moves to the lowest-indexed requesting initiator. If no initiator requests, the grant parks on initiator 0.
- R3: While `r_ready` is 0, `m_grant` does not change.
- R4: `s_addr`, `s_write` and `s_size` equal the address and control of the currently granted initiator, in the same cycle.
- R5: The address region is `addr[AW-1:REGION_LSB]`. Target k is selected (`s_sel[k]`=1) when the granted initiator requests and the region equals k. At most one select is high.
- R6: When the granted initiator is not requesting, `s_sel` is all zero.
- R7: `r_rdata`, `r_ready` and `r_resp` come from the target selected in the last address phase accepted with `r_ready`=1. While that target holds ready low, the data phase and the address phase in flight both stay in place.
- R8: An active address phase whose region matches no target yields a data phase with `r_ready`=1, `r_resp`=1 (error) and `r_rdata`=0.
- R9: A data phase that follows an idle address phase returns `r_ready`=1, `r_resp`=0 (okay) and `r_rdata`=0.
- R10: `s_wdata` is the write data of the initiator that owned the address phase of the current data phase. This holds even when the grant has since moved to another initiator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | N_MST | Per-initiator request, which also marks an active address phase |
| m_addr | input | N_MST*AW | Per-initiator address, packed |
| m_write | input | N_MST | Per-initiator direction (1 = write) |
| m_size | input | N_MST*SIZE_W | Per-initiator transfer size code, packed |
| m_wdata | input | N_MST*DW | Per-initiator write data, packed |
| m_grant | output | N_MST | One-hot grant |
| s_sel | output | N_SLV | One-hot target select for the address phase |
| s_addr | output | AW | Address broadcast to the targets |
| s_write | output | 1 | Direction broadcast to the targets |
| s_size | output | SIZE_W | Size broadcast to the targets |
| s_wdata | output | DW | Write data of the data-phase owner |
| s_rdata | input | N_SLV*DW | Per-target read data, packed |
| s_ready | input | N_SLV | Per-target ready |
| s_resp | input | N_SLV | Per-target response (1 = error) |
| r_rdata | output | DW | Read data returned to the initiators |
| r_ready | output | 1 | Ready returned to the initiators; also the transfer boundary |
| r_resp | output | 1 | Response returned to the initiators (1 = error) |

## Verification
The assertions check the following on every cycle:
- the grant is one-hot;
- at most one target select is high;
- the grant freezes during wait states;
- a request from initiator 0 wins at every boundary;
- the selects stay silent when no address phase is active;
- unmapped and idle address phases produce the right data-phase answer in the next cycle.

Only the bench scenarios can show the following:
- the one-cycle lag between a target's select and its read data;
- a stretched data phase that releases the grant to a lower-priority initiator once ready returns;
- write data still following the earlier initiator after the grant has moved on.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;

  typedef enum logic {
    RESP_OKAY  = 1'b0,
    RESP_ERROR = 1'b1
  } resp_e;

endpackage

// File: rtl/pbus_arbiter.sv
`timescale 1ns/1ps
module pbus_arbiter #(
  parameter int N_MST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] req,
  input  logic             advance,
  output logic [N_MST-1:0] grant
);

  logic [N_MST-1:0] pick;

  // lowest index wins; park on initiator 0 when nobody asks
  always_comb begin
    pick = '0;
    pick[0] = 1'b1;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= {{(N_MST-1){1'b0}}, 1'b1};
    end else if (advance) begin
      grant <= pick;
    end
  end

endmodule

// File: rtl/pbus_addr_decoder.sv
`timescale 1ns/1ps
module pbus_addr_decoder #(
  parameter int N_SLV    = 4,
  parameter int REGION_W = 20
) (
  input  logic                active,
  input  logic [REGION_W-1:0] region,
  output logic [N_SLV-1:0]    sel,
  output logic                miss
);

  for (genvar k = 0; k < N_SLV; k++) begin : g_hit
    assign sel[k] = active && (region == REGION_W'(k));
  end

  assign miss = active && !(|sel);

endmodule

// File: rtl/pbus_return_mux.sv
`timescale 1ns/1ps
module pbus_return_mux
  import pbus_pkg::*;
#(
  parameter int N_SLV = 4,
  parameter int DW    = 32
) (
  input  logic [N_SLV-1:0]    dp_slv,
  input  logic                dp_miss,
  input  logic [N_SLV*DW-1:0] s_rdata,
  input  logic [N_SLV-1:0]    s_ready,
  input  logic [N_SLV-1:0]    s_resp,
  output logic [DW-1:0]       rdata,
  output logic                ready,
  output logic                resp
);

  always_comb begin
    rdata = '0;
    ready = 1'b1;
    resp  = RESP_OKAY;
    if (dp_miss) begin
      resp = RESP_ERROR;
    end
    for (int k = 0; k < N_SLV; k++) begin
      if (dp_slv[k]) begin
        rdata = s_rdata[k*DW +: DW];
        ready = s_ready[k];
        resp  = s_resp[k];
      end
    end
  end

endmodule

// File: rtl/pbus_fabric.sv
`timescale 1ns/1ps
module pbus_fabric #(
  parameter int N_MST      = 3,
  parameter int N_SLV      = 4,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SIZE_W     = 3,
  parameter int REGION_LSB = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MST-1:0]     m_req,
  input  logic [N_MST*AW-1:0]  m_addr,
  input  logic [N_MST-1:0]     m_write,
  input  logic [N_MST*SIZE_W-1:0] m_size,
  input  logic [N_MST*DW-1:0]  m_wdata,
  output logic [N_MST-1:0]     m_grant,
  output logic [N_SLV-1:0]     s_sel,
  output logic [AW-1:0]        s_addr,
  output logic                 s_write,
  output logic [SIZE_W-1:0]    s_size,
  output logic [DW-1:0]        s_wdata,
  input  logic [N_SLV*DW-1:0]  s_rdata,
  input  logic [N_SLV-1:0]     s_ready,
  input  logic [N_SLV-1:0]     s_resp,
  output logic [DW-1:0]        r_rdata,
  output logic                 r_ready,
  output logic                 r_resp
);

  localparam int REGION_W = AW - REGION_LSB;

  logic             ap_active;
  logic             ap_miss;
  logic [N_SLV-1:0] dp_slv;
  logic             dp_miss;
  logic [N_MST-1:0] dp_mst;

  pbus_arbiter #(.N_MST(N_MST)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (m_req),
    .advance (r_ready),
    .grant   (m_grant)
  );

  // address and control path: AND-OR mux on the one-hot grant
  always_comb begin
    s_addr  = '0;
    s_write = 1'b0;
    s_size  = '0;
    for (int i = 0; i < N_MST; i++) begin
      s_addr  |= m_addr[i*AW +: AW] & {AW{m_grant[i]}};
      s_write |= m_write[i] & m_grant[i];
      s_size  |= m_size[i*SIZE_W +: SIZE_W] & {SIZE_W{m_grant[i]}};
    end
  end

  assign ap_active = |(m_req & m_grant);

  pbus_addr_decoder #(.N_SLV(N_SLV), .REGION_W(REGION_W)) u_dec (
    .active (ap_active),
    .region (s_addr[AW-1:REGION_LSB]),
    .sel    (s_sel),
    .miss   (ap_miss)
  );

  // data-phase owner, captured only at an accepted boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      dp_slv  <= '0;
      dp_miss <= 1'b0;
      dp_mst  <= {{(N_MST-1){1'b0}}, 1'b1};
    end else if (r_ready) begin
      dp_slv  <= s_sel;
      dp_miss <= ap_miss;
      dp_mst  <= m_grant;
    end
  end

  // write data path follows the data-phase owner
  always_comb begin
    s_wdata = '0;
    for (int i = 0; i < N_MST; i++) begin
      s_wdata |= m_wdata[i*DW +: DW] & {DW{dp_mst[i]}};
    end
  end

  pbus_return_mux #(.N_SLV(N_SLV), .DW(DW)) u_ret (
    .dp_slv  (dp_slv),
    .dp_miss (dp_miss),
    .s_rdata (s_rdata),
    .s_ready (s_ready),
    .s_resp  (s_resp),
    .rdata   (r_rdata),
    .ready   (r_ready),
    .resp    (r_resp)
  );

endmodule

// File: rtl/pbus_fabric_chk.sv
`timescale 1ns/1ps
module pbus_fabric_chk #(
  parameter int N_MST = 3,
  parameter int N_SLV = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [N_MST-1:0] m_req,
  input logic [N_MST-1:0] m_grant,
  input logic [N_SLV-1:0] s_sel,
  input logic [DW-1:0]    r_rdata,
  input logic             r_ready,
  input logic             r_resp
);

  logic active;
  assign active = |(m_req & m_grant);

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(m_grant) == 1);

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_sel));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !r_ready |=> $stable(m_grant));

  // R2
  top_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (r_ready && m_req[0]) |=> m_grant[0]);

  // R6
  idle_nosel_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> (s_sel == '0));

  // R8
  miss_err_chk: assert property (@(posedge clk) disable iff (rst)
    (r_ready && active && s_sel == '0) |=> (r_ready && r_resp && r_rdata == '0));

  // R9
  idle_dp_chk: assert property (@(posedge clk) disable iff (rst)
    (r_ready && !active) |=> (r_ready && !r_resp && r_rdata == '0));

endmodule

bind pbus_fabric pbus_fabric_chk #(.N_MST(N_MST), .N_SLV(N_SLV), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .m_req   (m_req),
  .m_grant (m_grant),
  .s_sel   (s_sel),
  .r_rdata (r_rdata),
  .r_ready (r_ready),
  .r_resp  (r_resp)
);

// File: tb/pbus_fabric_tb.sv
`timescale 1ns/1ps
module pbus_fabric_tb;

  localparam int N_MST = 3;
  localparam int N_SLV = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SIZE_W = 3;
  localparam int REGION_LSB = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_MST-1:0] m_req = '0;
  logic [N_MST*AW-1:0] m_addr = '0;
  logic [N_MST-1:0] m_write = '0;
  logic [N_MST*SIZE_W-1:0] m_size = '0;
  logic [N_MST*DW-1:0] m_wdata = '0;
  logic [N_MST-1:0] m_grant;
  logic [N_SLV-1:0] s_sel;
  logic [AW-1:0] s_addr;
  logic s_write;
  logic [SIZE_W-1:0] s_size;
  logic [DW-1:0] s_wdata;
  logic [N_SLV*DW-1:0] s_rdata;
  logic [N_SLV-1:0] s_ready = '1;
  logic [N_SLV-1:0] s_resp = '0;
  logic [DW-1:0] r_rdata;
  logic r_ready;
  logic r_resp;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pbus_fabric #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW), .DW(DW),
                .SIZE_W(SIZE_W), .REGION_LSB(REGION_LSB)) u_dut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_write(m_write),
    .m_size(m_size), .m_wdata(m_wdata), .m_grant(m_grant), .s_sel(s_sel),
    .s_addr(s_addr), .s_write(s_write), .s_size(s_size), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_ready(s_ready), .s_resp(s_resp),
    .r_rdata(r_rdata), .r_ready(r_ready), .r_resp(r_resp)
  );

  function automatic logic [DW-1:0] slv_data(int k);
    return 32'h5A00_0000 | DW'(k);
  endfunction

  function automatic logic [AW-1:0] region_addr(int k, int off);
    return (AW'(k) << REGION_LSB) | AW'(off);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 grant after reset", 64'(m_grant), 64'(3'b001));
    chk("R6 no select after reset", 64'(s_sel), 64'h0);
    chk("R9 idle ready", 64'(r_ready), 64'h1);
    chk("R9 idle resp", 64'(r_resp), 64'h0);
    chk("R9 idle rdata", 64'(r_rdata), 64'h0);
  endtask

  task automatic t_priority();
    m_req = 3'b110;
    m_addr[1*AW +: AW] = region_addr(3, 'h40);
    m_addr[2*AW +: AW] = region_addr(1, 'h10);
    #1;
    chk("R2 grant before edge", 64'(m_grant), 64'(3'b001));
    next_cycle(); #1;
    chk("R2 lowest requester wins", 64'(m_grant), 64'(3'b010));
    chk("R4 address of granted", 64'(s_addr), 64'(region_addr(3, 'h40)));
    chk("R5 select target 3", 64'(s_sel), 64'(4'b1000));
    m_req = 3'b111;
    m_addr[0 +: AW] = region_addr(0, 'h4);
    next_cycle(); #1;
    chk("R2 initiator 0 takes over", 64'(m_grant), 64'(3'b001));
    chk("R5 select target 0", 64'(s_sel), 64'(4'b0001));
    chk("R7 data from previous target", 64'(r_rdata), 64'(slv_data(3)));
  endtask

  task automatic t_unmapped();
    m_req = 3'b001;
    m_addr[0 +: AW] = 32'h0000_7000;
    #1;
    chk("R8 no select on miss", 64'(s_sel), 64'h0);
    next_cycle(); #1;
    chk("R8 miss ready", 64'(r_ready), 64'h1);
    chk("R8 miss error resp", 64'(r_resp), 64'h1);
    chk("R8 miss rdata", 64'(r_rdata), 64'h0);
  endtask

  task automatic t_wait();
    m_req = 3'b011;
    m_addr[0 +: AW] = region_addr(1, 'h0);
    m_addr[1*AW +: AW] = region_addr(2, 'h8);
    next_cycle();
    s_ready[1] = 1'b0;
    m_req = 3'b010;
    #1;
    chk("R7 wait propagates", 64'(r_ready), 64'h0);
    chk("R6 no select when granted idle", 64'(s_sel), 64'h0);
    next_cycle(); #1;
    chk("R3 grant held during wait", 64'(m_grant), 64'(3'b001));
    chk("R7 still waiting", 64'(r_ready), 64'h0);
    s_ready[1] = 1'b1;
    #1;
    chk("R7 ready released", 64'(r_ready), 64'h1);
    chk("R7 target 1 data", 64'(r_rdata), 64'(slv_data(1)));
    next_cycle(); #1;
    chk("R2 grant moves after wait", 64'(m_grant), 64'(3'b010));
    chk("R5 select target 2", 64'(s_sel), 64'(4'b0100));
  endtask

  task automatic t_wdata();
    m_write = 3'b010;
    m_wdata[1*DW +: DW] = 32'hDEAD_BEEF;
    m_wdata[0 +: DW] = 32'h1111_1111;
    m_size[1*SIZE_W +: SIZE_W] = 3'd2;
    #1;
    chk("R4 write flag of granted", 64'(s_write), 64'h1);
    chk("R4 size of granted", 64'(s_size), 64'd2);
    m_req = 3'b011;
    next_cycle(); #1;
    chk("R2 grant back to 0", 64'(m_grant), 64'(3'b001));
    chk("R10 wdata from data-phase owner", 64'(s_wdata), 64'hDEAD_BEEF);
    chk("R4 address follows new grant", 64'(s_addr), 64'(region_addr(1, 'h0)));
    chk("R4 write flag follows new grant", 64'(s_write), 64'h0);
  endtask

  task automatic t_idle();
    next_cycle();
    m_req = 3'b000;
    #1;
    chk("R7 target 1 read data", 64'(r_rdata), 64'(slv_data(1)));
    chk("R10 wdata of initiator 0", 64'(s_wdata), 64'h1111_1111);
    next_cycle(); #1;
    chk("R9 idle ready", 64'(r_ready), 64'h1);
    chk("R9 idle resp", 64'(r_resp), 64'h0);
    chk("R9 idle rdata", 64'(r_rdata), 64'h0);
    chk("R2 park on initiator 0", 64'(m_grant), 64'(3'b001));
  endtask

  initial begin
    for (int k = 0; k < N_SLV; k++) s_rdata[k*DW +: DW] = slv_data(k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    next_cycle();
    t_reset();
    t_priority();
    t_unmapped();
    t_wait();
    t_wdata();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule